// File: doc/BRIEF.md
# ASCII Hex Response Encoder

This block turns a parallel read-response word into a fixed-length text line and hands that line, one byte at a time, to a downstream byte transmitter such as a UART transmit stage. A line consists of a single marker letter, the word written as hexadecimal digits, and a carriage-return/line-feed pair. With the default 16-bit word, every line is exactly seven bytes long.

A producer presents a word with a one-cycle valid strobe while the encoder is idle. The encoder captures the word and raises its busy flag. It then issues each byte with a one-cycle start pulse and holds the byte steady until the transmitter reports, with a done pulse, that the byte has gone out. Only after that does it move to the next byte. Busy drops once the transmitter has reported the final line feed. A strobe that arrives while a line is in progress is discarded.

The word width must be a multiple of four. Both the marker character and the case of the hex letters are parameters. The defaults are a 16-bit word, the marker 'D' and uppercase letters.

Top module: `hexenc_top`

## Requirements
- R1: The first byte of every line is the marker character, ASCII 'D' (0x44) by default.
- R2: After the marker, the word is sent as DATA_W/4 hex digits (four by default), most significant nibble first, with leading zero digits kept.
- R3: A nibble value 0 to 9 is sent as 0x30 to 0x39. A value 10 to 15 is sent as 0x41 to 0x46, which are uppercase letters.
- R4: Every line ends with 0x0D followed by 0x0A and contains exactly DATA_W/4+3 bytes (seven by default). Every word value from 0x0000 to 0xFFFF encodes this way.
- R5: tx_start is high for a single cycle per byte. The next tx_start comes only after tx_done has been seen for the previous byte, and tx_byte does not change between a start and its done.
- R6: A word_valid seen while busy is low latches word_data. busy is high from the next cycle, and the marker byte is started in that same cycle. busy stays high until the cycle after tx_done for the final line feed.
- R7: word_valid pulses while busy is high are ignored: the line in progress is unchanged and no extra line is sent.
- R8: Changes on word_data after the word has been captured have no effect on the line being sent.
- R9: While reset is active and after it is released, busy and tx_start are low.
- R10: A tx_done pulse while no byte is outstanding is ignored: it starts nothing and does not change busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | One-cycle strobe that marks word_data as a new response |
| word_data | input | DATA_W | Response word to be encoded |
| busy | output | 1 | High while a line is being sent |
| tx_start | output | 1 | One-cycle request to the transmitter to send tx_byte |
| tx_byte | output | 8 | Current byte of the line |
| tx_done | input | 1 | Transmitter pulse that marks the current byte as sent |

## Verification
The assertions check on every cycle the parts of the handshake that can be judged locally. They check that tx_start is a single pulse and is never raised while idle, that tx_byte is held while a byte is outstanding, that a line opens with the marker, and that each digit byte is a legal hex character. They also check that the byte index advances by one per done and that the line closes after the line-feed done. Only the bench scenarios can show that the whole byte sequence matches the word digit for digit. The same holds for the behaviour under varied transmitter latencies, for strobes ignored while busy, for spurious done pulses, and for the extreme values 0x0000 and 0xFFFF.

// File: rtl/hexenc_pkg.sv
package hexenc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } enc_state_t;

   localparam logic [7:0] CHAR_CR    = 8'h0D;
   localparam logic [7:0] CHAR_LF    = 8'h0A;
   localparam logic [7:0] CHAR_ZERO  = 8'h30;
   localparam logic [7:0] CHAR_UPPER = 8'h41;
   localparam logic [7:0] CHAR_LOWER = 8'h61;

endpackage

// File: rtl/hexenc_nibble2ascii.sv
module hexenc_nibble2ascii
   import hexenc_pkg::*;
#(
   parameter bit UPPER = 1'b1
) (
   input  logic [3:0] nib,
   output logic [7:0] chr
);

   logic [7:0] letter_base;

   generate
      if (UPPER) begin : g_upper
         assign letter_base = CHAR_UPPER;
      end else begin : g_lower
         assign letter_base = CHAR_LOWER;
      end
   endgenerate

   always_comb begin
      if (nib < 4'd10) chr = CHAR_ZERO + {4'd0, nib};
      else             chr = letter_base + {4'd0, nib} - 8'd10;
   end

endmodule

// File: rtl/hexenc_byte_mux.sv
module hexenc_byte_mux
   import hexenc_pkg::*;
#(
   parameter int         DATA_W    = 16,
   parameter logic [7:0] LEAD_CHAR = 8'h44,
   parameter bit         UPPER     = 1'b1,
   parameter int         IDX_W     = 3
) (
   input  logic [DATA_W-1:0] word,
   input  logic [IDX_W-1:0]  idx,
   output logic [7:0]        chr
);

   localparam int NDIG = DATA_W / 4;

   logic [7:0] digit_chr [NDIG];

   generate
      for (genvar g = 0; g < NDIG; g++) begin : g_digit
         hexenc_nibble2ascii #(.UPPER(UPPER)) i_n2a (
            .nib (word[DATA_W-1-4*g -: 4]),
            .chr (digit_chr[g])
         );
      end
   endgenerate

   always_comb begin
      if (idx == '0)                        chr = LEAD_CHAR;
      else if (idx == IDX_W'(NDIG + 1))     chr = CHAR_CR;
      else                                  chr = CHAR_LF;
      for (int g = 0; g < NDIG; g++) begin
         if (idx == IDX_W'(g + 1)) chr = digit_chr[g];
      end
   end

endmodule

// File: rtl/hexenc_seq.sv
module hexenc_seq
   import hexenc_pkg::*;
#(
   parameter int NBYTES = 7,
   parameter int IDX_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             tx_done,
   output enc_state_t       state,
   output logic [IDX_W-1:0] idx,
   output logic             last
);

   enc_state_t state_n;
   logic [IDX_W-1:0] idx_n;

   assign last = (idx == IDX_W'(NBYTES - 1));

   always_comb begin
      state_n = state;
      idx_n   = idx;
      case (state)
         ST_IDLE: begin
            if (accept) begin
               state_n = ST_ISSUE;
               idx_n   = '0;
            end
         end
         ST_ISSUE: state_n = ST_WAIT;
         ST_WAIT: begin
            if (tx_done) begin
               if (last) begin
                  state_n = ST_IDLE;
               end else begin
                  state_n = ST_ISSUE;
                  idx_n   = idx + 1'b1;
               end
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         state <= state_n;
         idx   <= idx_n;
      end
   end

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && tx_done && !last) |=> (state == ST_ISSUE && idx == $past(idx) + 1'b1)); // R4

   AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !accept && tx_done) |=> (state == ST_IDLE)); // R10

endmodule

// File: rtl/hexenc_top.sv
module hexenc_top
   import hexenc_pkg::*;
#(
   parameter int         DATA_W    = 16,
   parameter logic [7:0] LEAD_CHAR = 8'h44,
   parameter bit         UPPER     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   input  logic [DATA_W-1:0] word_data,
   output logic              busy,
   output logic              tx_start,
   output logic [7:0]        tx_byte,
   input  logic              tx_done
);

   localparam int NDIG   = DATA_W / 4;
   localparam int NBYTES = NDIG + 3;
   localparam int IDX_W  = $clog2(NBYTES);

   generate
      if (DATA_W % 4 != 0 || DATA_W < 4) begin : g_bad_width
         $error("hexenc_top: DATA_W must be a positive multiple of 4");
      end
   endgenerate

   enc_state_t       state;
   logic [IDX_W-1:0] idx;
   logic             last;
   logic             accept;
   logic [DATA_W-1:0] word_q;

   assign accept   = word_valid && (state == ST_IDLE);
   assign busy     = (state != ST_IDLE);
   assign tx_start = (state == ST_ISSUE);

   always_ff @(posedge clk) begin
      if (!rst_n)      word_q <= '0;
      else if (accept) word_q <= word_data;
   end

   hexenc_seq #(.NBYTES(NBYTES), .IDX_W(IDX_W)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .tx_done (tx_done),
      .state   (state),
      .idx     (idx),
      .last    (last)
   );

   hexenc_byte_mux #(
      .DATA_W    (DATA_W),
      .LEAD_CHAR (LEAD_CHAR),
      .UPPER     (UPPER),
      .IDX_W     (IDX_W)
   ) i_mux (
      .word (word_q),
      .idx  (idx),
      .chr  (tx_byte)
   );

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R5

   AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !tx_done) |=> $stable(tx_byte)); // R5

   AST_LEAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (tx_start && tx_byte == LEAD_CHAR)); // R1

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_start); // R6

   AST_LINE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && tx_done && last) |=> !busy); // R4

   AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && word_valid) |=> $stable(word_q)); // R7

   AST_HEX_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && idx != '0 && idx <= IDX_W'(NDIG)) |->
         ((tx_byte >= 8'h30 && tx_byte <= 8'h39) ||
          (UPPER  && tx_byte >= 8'h41 && tx_byte <= 8'h46) ||
          (!UPPER && tx_byte >= 8'h61 && tx_byte <= 8'h66))); // R3

endmodule

// File: tb/test_hexenc_top.sv
`timescale 1ns/1ps
module test_hexenc_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        word_valid;
   logic [15:0] word_data;
   logic        busy;
   logic        tx_start;
   logic [7:0]  tx_byte;
   logic        tx_done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [7:0] rec [0:31];
   int   nrec = 0;
   bit   pend = 0;
   int   dly  = 0;
   bit   spurious = 0;
   int   seed_dummy;

   always #2 clk = ~clk;

   hexenc_top i_hexenc_top (
      .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
      .busy(busy), .tx_start(tx_start), .tx_byte(tx_byte), .tx_done(tx_done)
   );

   function automatic logic [7:0] hexch(input logic [3:0] n);
      return (n < 4'd10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
   endfunction

   function automatic logic [7:0] exp_byte(input logic [15:0] w, input int i);
      case (i)
         0: return 8'h44;
         1: return hexch(w[15:12]);
         2: return hexch(w[11:8]);
         3: return hexch(w[7:4]);
         4: return hexch(w[3:0]);
         5: return 8'h0D;
         default: return 8'h0A;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // transmitter model
   initial begin
      tx_done = 1'b0;
      forever begin
         @(negedge clk);
         tx_done = 1'b0;
         if (spurious) begin
            tx_done  = 1'b1;
            spurious = 0;
         end
         if (pend) begin
            if (dly == 0) begin
               chk(tx_byte == rec[nrec-1], "R5 byte held", tx_byte, rec[nrec-1]);
               tx_done = 1'b1;
               pend = 0;
            end else dly--;
         end
         if (tx_start) begin
            chk(!pend, "R5 start before done", 1, 0);
            if (nrec < 32) rec[nrec] = tx_byte;
            nrec++;
            pend = 1;
            dly  = int'($urandom % 4);
         end
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   task automatic wait_idle();
      for (int k = 0; k < 200 && busy; k++) @(negedge clk);
   endtask

   task automatic send_line(input logic [15:0] w, input bit poke_busy);
      wait_idle();
      nrec = 0;
      word_valid = 1'b1;
      word_data  = w;
      @(negedge clk);
      word_valid = 1'b0;
      word_data  = 16'($urandom);          // R8: must not affect line
      chk(busy == 1'b1, "R6 busy after accept", busy, 1);
      if (poke_busy) begin
         @(negedge clk);
         word_valid = 1'b1;                // R7: ignored while busy
         word_data  = ~w;
         @(negedge clk);
         word_valid = 1'b0;
      end
      wait_idle();
      chk(nrec == 7, "R4 byte count", nrec, 7);
      for (int i = 0; i < 7; i++)
         chk(rec[i] == exp_byte(w, i), (i == 0) ? "R1 marker" :
             (i < 5) ? "R2/R3 digit" : "R4 terminator", rec[i], exp_byte(w, i));
   endtask

   initial begin
      seed_dummy = $urandom(32'h5eed_1234);
      rst_n = 1'b0; word_valid = 1'b0; word_data = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !tx_start, "R9 reset in", {busy, tx_start}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !tx_start, "R9 after reset", {busy, tx_start}, 0);

      // R10: spurious done while idle
      spurious = 1;
      repeat (3) @(negedge clk);
      chk(!busy && nrec == 0, "R10 spurious done", {busy, 8'(nrec)}, 0);

      // directed corners (R2 leading zeros, R3 letters)
      send_line(16'h0000, 0);
      send_line(16'hFFFF, 0);
      send_line(16'h09AF, 0);
      send_line(16'h000A, 0);
      send_line(16'h1234, 1);   // R7
      send_line(16'hA5F0, 1);   // R7
      // R7: no extra line after ignored strobe
      repeat (10) @(negedge clk);
      chk(!busy && nrec == 7, "R7 no extra line", nrec, 7);

      for (int n = 0; n < 400; n++)
         send_line(16'($urandom), ($urandom % 4) == 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule